// File: doc/BRIEF.md
# Sliced-Data Interrupt and Caption Readback Controller

This block sits between a video data slicer and a host register port. The slicer raises a one-cycle detection pulse for each of four kinds of captured data: caption, copy-generation/widescreen, guide/program-code/time, and timecode. For each kind the block keeps a sticky status bit, a mask bit and a write-one-to-clear control. It drives one active-high interrupt line, which is the OR over the four sources of status AND mask.

Caption data gets extra handling. The payload that comes with a caption detection is latched into a readback buffer, and a caption-available flag goes high. The buffer then stays frozen until software writes a separate release register. Acknowledging the caption interrupt does not release the buffer. It only takes the interrupt request away. Software therefore follows a fixed sequence: take the interrupt, clear its status, read the buffer, then release the buffer so the next caption can be captured.

The host port is a plain strobe interface. A write takes effect on the clock edge where `host_wr` is high. A read returns data on `host_rdata` one cycle after the edge where `host_rd` is high.

Top module: `slice_irq_ctrl`

## Requirements
- R1: After reset the status register, the mask register, the caption-available flag and `irq` are all 0.
- R2: Source k maps to data bit 2k of the status, clear and mask registers: caption is k=0 (bit 0), copy-gen/widescreen is k=1 (bit 2), guide/program/time is k=2 (bit 4), timecode is k=3 (bit 6). A pulse on `slc_det[k]` for k=1..3 sets status bit 2k at address 0x4E on the next edge. The bit stays set until it is cleared. Other bits of 0x4E read 0.
- R3: A write to 0x4F with bit 2k set clears status bit 2k on that edge. The clear bits are self-clearing: reading 0x4F always returns 0.
- R4: The mask register at 0x50 is read/write on bits 0, 2, 4 and 6, and its other bits read 0. `irq` is high exactly when some source has both its status bit and its mask bit set. With all mask bits 0, `irq` stays low.
- R5: If a detection and a clear for the same source fall in the same cycle, the detection wins and the status bit stays set.
- R6: A mask write that changes a bit from 0 to 1 clears that source's status bit, unless the same source is detected in that cycle.
- R7: When `slc_det[0]` pulses and the caption buffer is empty, the buffer takes `slc_cap_data`, the available flag sets, and status bit 0 sets.
- R8: While the available flag is set, caption detections are dropped. The buffer keeps its contents and status bit 0 is not set again.
- R9: Clearing caption status through 0x4F leaves the available flag and the buffer contents unchanged.
- R10: Writing 0x78 with bit 0 set clears the available flag. The next caption detection then updates the buffer.
- R11: Reading 0x78 returns the available flag in bit 0. The buffer is read as bytes starting at 0x79, least significant byte first.
- R12: Writes to the read-only status register 0x4E have no effect, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data, valid one cycle after `host_rd` |
| slc_det | input | 4 | One-cycle detection pulse per source (bit k = source k) |
| slc_cap_data | input | CAP_W | Caption payload, valid with `slc_det[0]` |
| irq | output | 1 | Active-high interrupt request |

## Verification
Detections are first applied with all sources masked, which shows that status latching is independent of the interrupt path. They are then applied after an unmask, which separates statuses left over from before the unmask from fresh ones. A detection and a clear are driven in the same cycle to show which of the two has priority. Two caption payloads that differ are sent around the clear and release writes. Reading back which payload is held shows whether the interrupt acknowledge and the buffer release are really independent, and whether dropped captions leave the buffer alone.

// File: rtl/slice_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and bit-placement helpers for the sliced-data
// interrupt controller. Assumes an 8-bit register bus with sources placed
// on even data bits.
package slice_irq_pkg;

    localparam int REG_AW     = 8;
    localparam int REG_DW     = 8;
    localparam int NUM_SRC    = 4;
    localparam int SRC_STRIDE = 2;

    localparam logic [REG_AW-1:0] ADDR_STATUS  = 8'h4E;
    localparam logic [REG_AW-1:0] ADDR_CLEAR   = 8'h4F;
    localparam logic [REG_AW-1:0] ADDR_MASK    = 8'h50;
    localparam logic [REG_AW-1:0] ADDR_RELEASE = 8'h78;
    localparam logic [REG_AW-1:0] ADDR_CAPBUF  = 8'h79;

    typedef enum int unsigned {
        SRC_CAPTION  = 0,
        SRC_COPYGEN  = 1,
        SRC_GUIDE    = 2,
        SRC_TIMECODE = 3
    } src_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] wdata;
    } host_req_t;

    // Place one flag per source on its register bit.
    function automatic logic [REG_DW-1:0] spread(input logic [NUM_SRC-1:0] v);
        logic [REG_DW-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) r[i*SRC_STRIDE] = v[i];
        return r;
    endfunction

    // Pick one flag per source out of a register data word.
    function automatic logic [NUM_SRC-1:0] gather(input logic [REG_DW-1:0] d);
        logic [NUM_SRC-1:0] r;
        for (int i = 0; i < NUM_SRC; i++) r[i] = d[i*SRC_STRIDE];
        return r;
    endfunction

endpackage

// File: rtl/slice_irq_src.sv
`timescale 1ns/1ps
// One interrupt source: a sticky status bit and its mask bit.
// Priority for the status bit: a set beats a clear, and a clear beats the
// implicit clear that an unmask causes.
// Assumes set_i is a single-cycle event and the mask write is decoded upstream.
module slice_irq_src (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_wr_i,
    input  logic mask_d_i,
    output logic stat_o,
    output logic mask_o,
    output logic req_o
);
    logic stat_q;
    logic mask_q;
    logic unmask;

    // Purpose: detect a 0-to-1 mask transition.
    always_comb unmask = mask_wr_i & mask_d_i & ~mask_q;

    // Purpose: hold the mask bit.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= 1'b0;
        else if (mask_wr_i) mask_q <= mask_d_i;
    end

    // Purpose: sticky status with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                stat_q <= 1'b0;
        else if (set_i)            stat_q <= 1'b1;
        else if (clr_i || unmask)  stat_q <= 1'b0;
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign req_o  = stat_q & mask_q;
endmodule

// File: rtl/slice_cap_buf.sv
`timescale 1ns/1ps
// Caption readback buffer. It latches the payload on a detection only while
// empty, and stays frozen until a release clears the available flag.
// Assumes data_i is valid in the cycle det_i is high.
module slice_cap_buf #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    input  logic [CAP_W-1:0] data_i,
    input  logic             rel_i,
    output logic             capture_o,
    output logic             avail_o,
    output logic [CAP_W-1:0] buf_o
);
    logic             avail_q;
    logic [CAP_W-1:0] buf_q;

    // Purpose: accept a caption only into an empty buffer.
    always_comb capture_o = det_i & ~avail_q;

    // Purpose: available flag, set on capture and cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)         avail_q <= 1'b0;
        else if (capture_o) avail_q <= 1'b1;
        else if (rel_i)     avail_q <= 1'b0;
    end

    // Purpose: payload storage, written only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         buf_q <= '0;
        else if (capture_o) buf_q <= data_i;
    end

    assign avail_o = avail_q;
    assign buf_o   = buf_q;
endmodule

// File: rtl/slice_irq_regif.sv
`timescale 1ns/1ps
// Host register decode and registered read mux.
// Assumes one access per strobe. Read data appears one cycle after the read.
module slice_irq_regif
    import slice_irq_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  host_req_t           req,
    input  logic [NUM_SRC-1:0]  stat_i,
    input  logic [NUM_SRC-1:0]  mask_i,
    input  logic                avail_i,
    input  logic [CAP_W-1:0]    cap_buf_i,
    output logic [NUM_SRC-1:0]  clr_o,
    output logic                mask_wr_o,
    output logic [NUM_SRC-1:0]  mask_d_o,
    output logic                rel_o,
    output logic [REG_DW-1:0]   rdata_o
);
    localparam int CAP_BYTES = (CAP_W + REG_DW - 1) / REG_DW;

    logic [CAP_BYTES*REG_DW-1:0] cap_pad;
    logic [REG_DW-1:0]           rd_mux;
    logic [REG_DW-1:0]           rdata_q;

    // Purpose: decode writes into per-source clear, mask and release strobes.
    always_comb begin
        clr_o     = (req.wr && req.addr == ADDR_CLEAR) ? gather(req.wdata) : '0;
        mask_wr_o = req.wr && req.addr == ADDR_MASK;
        mask_d_o  = gather(req.wdata);
        rel_o     = req.wr && req.addr == ADDR_RELEASE && req.wdata[0];
    end

    // Purpose: zero-extend the buffer to a whole number of bytes.
    always_comb begin
        cap_pad             = '0;
        cap_pad[CAP_W-1:0]  = cap_buf_i;
    end

    // Purpose: select read data by address.
    always_comb begin
        rd_mux = '0;
        case (req.addr)
            ADDR_STATUS:  rd_mux = spread(stat_i);
            ADDR_MASK:    rd_mux = spread(mask_i);
            ADDR_RELEASE: rd_mux = {{(REG_DW-1){1'b0}}, avail_i};
            default:      rd_mux = '0;
        endcase
        for (int k = 0; k < CAP_BYTES; k++) begin
            if (req.addr == ADDR_CAPBUF + REG_AW'(k))
                rd_mux = cap_pad[k*REG_DW +: REG_DW];
        end
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/slice_irq_ctrl.sv
`timescale 1ns/1ps
// Top level of the sliced-data interrupt controller: four sticky sources,
// a caption readback buffer with its own release, and a host register port.
// Assumes one-cycle detection pulses from the slicer and a synchronous host.
module slice_irq_ctrl
    import slice_irq_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [REG_AW-1:0]  host_addr,
    input  logic [REG_DW-1:0]  host_wdata,
    output logic [REG_DW-1:0]  host_rdata,
    input  logic [NUM_SRC-1:0] slc_det,
    input  logic [CAP_W-1:0]   slc_cap_data,
    output logic               irq
);
    host_req_t          req;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_hit;
    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] req_vec;
    logic               mask_wr;
    logic               rel_hit;
    logic               cap_capture;
    logic               cap_avail;
    logic [CAP_W-1:0]   cap_buf;

    // Purpose: bundle the host strobes.
    always_comb req = '{wr: host_wr, rd: host_rd, addr: host_addr, wdata: host_wdata};

    slice_cap_buf #(.CAP_W(CAP_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_i     (slc_det[SRC_CAPTION]),
        .data_i    (slc_cap_data),
        .rel_i     (rel_hit),
        .capture_o (cap_capture),
        .avail_o   (cap_avail),
        .buf_o     (cap_buf)
    );

    // Purpose: caption status follows captures; the others follow raw pulses.
    always_comb begin
        set_vec              = slc_det;
        set_vec[SRC_CAPTION] = cap_capture;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        slice_irq_src u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[g]),
            .clr_i     (clr_hit[g]),
            .mask_wr_i (mask_wr),
            .mask_d_i  (mask_d[g]),
            .stat_o    (stat_q[g]),
            .mask_o    (mask_q[g]),
            .req_o     (req_vec[g])
        );
    end

    slice_irq_regif #(.CAP_W(CAP_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .stat_i    (stat_q),
        .mask_i    (mask_q),
        .avail_i   (cap_avail),
        .cap_buf_i (cap_buf),
        .clr_o     (clr_hit),
        .mask_wr_o (mask_wr),
        .mask_d_o  (mask_d),
        .rel_o     (rel_hit),
        .rdata_o   (host_rdata)
    );

    // Purpose: combine masked requests into the interrupt line.
    always_comb irq = |req_vec;
endmodule

// File: rtl/slice_irq_ctrl_chk.sv
`timescale 1ns/1ps
// Temporal checks on the interrupt controller, attached by bind.
// Assumes the internal names of slice_irq_ctrl.
module slice_irq_ctrl_chk
    import slice_irq_pkg::*;
#(
    parameter int CAP_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] set_vec,
    input logic [NUM_SRC-1:0] clr_hit,
    input logic               mask_wr,
    input logic [NUM_SRC-1:0] mask_d,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               rel_hit,
    input logic               cap_capture,
    input logic               cap_avail,
    input logic [CAP_W-1:0]   cap_buf,
    input logic [CAP_W-1:0]   slc_cap_data,
    input logic               irq
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> stat_q[g]);
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && !set_vec[g]) |=> !stat_q[g]);
        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit[g] && set_vec[g]) |=> stat_q[g]);
        p_unmask_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_wr && mask_d[g] && !mask_q[g] && !set_vec[g]) |=> !stat_q[g]);
    end

    p_no_mask_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_capture |=> (cap_avail && cap_buf == $past(slc_cap_data)));
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_avail && !rel_hit) |=> (cap_avail && $stable(cap_buf)));
    p_ack_keeps_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit[0] && cap_avail && !rel_hit) |=> cap_avail);
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_hit && cap_avail) |=> !cap_avail);
endmodule

bind slice_irq_ctrl slice_irq_ctrl_chk #(.CAP_W(CAP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_vec      (set_vec),
    .clr_hit      (clr_hit),
    .mask_wr      (mask_wr),
    .mask_d       (mask_d),
    .stat_q       (stat_q),
    .mask_q       (mask_q),
    .rel_hit      (rel_hit),
    .cap_capture  (cap_capture),
    .cap_avail    (cap_avail),
    .cap_buf      (cap_buf),
    .slc_cap_data (slc_cap_data),
    .irq          (irq)
);

// File: tb/tb_slice_irq_ctrl.sv
`timescale 1ns/1ps
module tb_slice_irq_ctrl;
    localparam int CAP_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr = 1'b0;
    logic             host_rd = 1'b0;
    logic [7:0]       host_addr = '0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic [3:0]       slc_det = '0;
    logic [CAP_W-1:0] slc_cap_data = '0;
    logic             irq;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2.5 clk = ~clk;

    slice_irq_ctrl #(.CAP_W(CAP_W)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .slc_det(slc_det), .slc_cap_data(slc_cap_data), .irq(irq)
    );

    always @(posedge clk) rd_seen <= host_rd;

    // Monitor: compare each returned read against the scoreboard.
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: read data %02h", host_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                if (host_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %02h actual %02h expected %02h",
                             it.tag, it.addr, host_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] det = 4'h0);
        host_addr = a; host_wdata = d; host_wr = 1'b1; slc_det = det;
        @(negedge clk);
        host_wr = 1'b0; slc_det = '0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] det, input logic [CAP_W-1:0] d = '0);
        slc_det = det; slc_cap_data = d;
        @(negedge clk);
        slc_det = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_exp(8'h4E, 8'h00, "R1 status");
        rd_exp(8'h50, 8'h00, "R1 mask");
        rd_exp(8'h78, 8'h00, "R1 avail");
        chk_irq(1'b0, "R1");

        // R2: masked detection latches status; R4 no irq while masked
        pulse(4'b0010);
        rd_exp(8'h4E, 8'h04, "R2 copygen status");
        chk_irq(1'b0, "R4 masked");

        // R6: unmask clears old status
        wr(8'h50, 8'h04);
        rd_exp(8'h4E, 8'h00, "R6 unmask clears");
        rd_exp(8'h50, 8'h04, "R4 mask readback");
        chk_irq(1'b0, "R6");

        // R4: fresh detection after unmask raises irq
        pulse(4'b0010);
        chk_irq(1'b1, "R4 unmasked");

        // R3: clear and self-clearing clear register
        wr(8'h4F, 8'h04);
        chk_irq(1'b0, "R3 after clear");
        rd_exp(8'h4E, 8'h00, "R3 status");
        rd_exp(8'h4F, 8'h00, "R3 clear reads 0");

        // R2 and R5: two sources, then a clear that collides with a detection
        pulse(4'b1100);
        rd_exp(8'h4E, 8'h50, "R2 guide+timecode");
        wr(8'h4F, 8'h10, 4'b0100);
        rd_exp(8'h4E, 8'h50, "R5 detect wins");
        wr(8'h4F, 8'h50);
        rd_exp(8'h4E, 8'h00, "R3 both cleared");

        // R7 and R11: caption capture
        wr(8'h50, 8'h45);
        pulse(4'b0001, 16'hBEEF);
        chk_irq(1'b1, "R7 caption irq");
        rd_exp(8'h4E, 8'h01, "R7 caption status");
        rd_exp(8'h78, 8'h01, "R11 avail");
        rd_exp(8'h79, 8'hEF, "R11 low byte");
        rd_exp(8'h7A, 8'hBE, "R11 high byte");

        // R9: acknowledge keeps buffer
        wr(8'h4F, 8'h01);
        chk_irq(1'b0, "R9 ack drops irq");
        rd_exp(8'h78, 8'h01, "R9 avail kept");
        rd_exp(8'h79, 8'hEF, "R9 data kept");

        // R8: new caption dropped while unreleased
        pulse(4'b0001, 16'h1234);
        chk_irq(1'b0, "R8 no irq");
        rd_exp(8'h4E, 8'h00, "R8 status not set");
        rd_exp(8'h79, 8'hEF, "R8 low byte kept");
        rd_exp(8'h7A, 8'hBE, "R8 high byte kept");

        // R10: release, then next caption captured
        wr(8'h78, 8'h01);
        rd_exp(8'h78, 8'h00, "R10 avail cleared");
        pulse(4'b0001, 16'h1234);
        chk_irq(1'b1, "R10 recapture irq");
        rd_exp(8'h79, 8'h34, "R10 low byte");
        rd_exp(8'h7A, 8'h12, "R10 high byte");

        // R2: timecode with its mask set
        pulse(4'b1000);
        rd_exp(8'h4E, 8'h41, "R2 timecode");

        // R12: status register is read-only; unmapped reads 0
        wr(8'h4E, 8'h00);
        rd_exp(8'h4E, 8'h41, "R12 status write ignored");
        rd_exp(8'h00, 8'h00, "R12 unmapped");
        wr(8'h50, 8'hFF);
        rd_exp(8'h50, 8'h55, "R4 mask odd bits read 0");
        chk_irq(1'b1, "R4 irq held");

        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule